// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends asynchronous serial frames on one output line, which rests high when nothing is being sent. A host writes bytes into a one-word output register. From there each word moves to a holding stage, and then to a shift register that drives the line. An outside divider supplies the bit timing as a one-cycle enable pulse, and every bit on the line lasts from one pulse to the next. Because the holding stage can be refilled while the shifter is busy, the host can keep the line fully loaded with no idle time between frames.

Three configuration inputs set the behaviour: a transmit enable, a two-bit frame format select, and one shared auxiliary bit. In the 9-bit format the auxiliary bit is the ninth data bit. In the parity format it chooses even or odd parity. Two status flags report progress. `hold_empty` tells the host when it may write, and it is the only flag to use for flow control. `tx_end` tells when the line has finished its last frame. Clearing the enable does not cut a frame short: the frame on the line runs to its final stop bit, and any word still waiting stays held until the enable is set again.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_empty` is 1 and `tx_end` is 1.
- R2: A write (`wr_en` high for one cycle) made while `hold_empty` is 1 is accepted, and `hold_empty` reads 0 in the next cycle. A write made while `hold_empty` is 0 is dropped and produces no frame.
- R3: While `tx_enable` is 0, no new frame starts. A word accepted while disabled is sent once `tx_enable` becomes 1.
- R4: Each frame is a low start bit, then the data bits with the least significant bit first, then any parity or ninth bit, then high stop bits. `tx_line` changes only on clock edges where `tick` is high, so each bit lasts one tick interval.
- R5: `fmt` = 00 sends 8 data bits and 1 stop bit (10 bit times). `fmt` = 01 sends 8 data bits and 2 stop bits (11 bit times).
- R6: `fmt` = 10 sends 8 data bits, then a parity bit, then 1 stop bit. The parity bit is the XOR of the data bits XOR `aux_bit`, so `aux_bit` = 0 gives even parity and `aux_bit` = 1 gives odd parity.
- R7: `fmt` = 11 sends 9 data bits and 1 stop bit. `aux_bit` is the ninth (most significant) data bit, sent right after data bit 7.
- R8: `tx_end` goes to 0 on the tick edge where a start bit begins. It goes to 1 on the tick edge that ends the last stop bit, unless another frame starts on that same edge. While the shifter is sending, `hold_empty` may be 1 while `tx_end` is 0.
- R9: If a word is waiting in the holding stage, its start bit begins on the tick right after the previous frame's last stop bit, with no idle bit time between the two frames.
- R10: If `tx_enable` is cleared in the middle of a frame, that frame is sent to its end. A word waiting in the holding stage is then kept, with `hold_empty` at 0, until the enable returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Byte written by the host |
| tick | input | 1 | Bit-rate enable pulse from the baud divider |
| tx_enable | input | 1 | Transmit enable |
| fmt | input | 2 | Frame format: 00 8N1, 01 8N2, 10 8 data + parity, 11 9N1 |
| aux_bit | input | 1 | Ninth data bit (fmt 11) or parity select (fmt 10) |
| tx_line | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | The host may write |
| tx_end | output | 1 | The last frame has finished |

## Verification
The bench uses the package defaults: an 8-bit data word, so frames are at most 11 bits long, with a tick every four clock cycles. At this size a full frame takes about 44 cycles. That makes it cheap to send every one of the 256 byte values under both auxiliary settings in the parity and 9-bit formats, plus a spread of 48 values in each of the two plain formats. The bench decodes every frame back from the line and compares it with a frame it builds arithmetically. It also checks the gaps between frames, the flag timing, writes made while disabled, and the enable being cleared in mid-frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FMT_8N1 = 2'b00,
        FMT_8N2 = 2'b01,
        FMT_8P1 = 2'b10,
        FMT_9N1 = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // bit 0 goes out first
        logic [CNT_W-1:0]   len;    // number of bit times
    } frame_t;

    // Lay out one frame, LSB first, with stop bits filling the top.
    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input fmt_e              f,
                                           input logic              aux);
        frame_t fr;
        fr.bits            = '1;
        fr.bits[0]         = 1'b0;
        fr.bits[DATA_W:1]  = d;
        unique case (f)
            FMT_8N1: fr.len = CNT_W'(DATA_W + 2);
            FMT_8N2: fr.len = CNT_W'(DATA_W + 3);
            FMT_8P1: begin
                fr.bits[DATA_W+1] = (^d) ^ aux;
                fr.len            = CNT_W'(DATA_W + 3);
            end
            default: begin
                fr.bits[DATA_W+1] = aux;
                fr.len            = CNT_W'(DATA_W + 3);
            end
        endcase
        return fr;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              take,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);

    logic              pend;
    logic [DATA_W-1:0] pend_q;
    logic              wr_ok;
    logic              move;

    assign hold_empty = !pend && !hold_full;
    assign wr_ok      = wr_en && hold_empty;
    assign move       = pend && !hold_full && tx_enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            hold_full <= 1'b0;
        end else begin
            if (wr_ok) begin
                pend   <= 1'b1;
                pend_q <= wr_data;
            end
            if (take) begin
                hold_full <= 1'b0;
            end
            if (move) begin
                hold_full <= 1'b1;
                hold_data <= pend_q;
                pend      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_enable,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  fmt_e              fmt,
    input  logic              aux_bit,
    output logic              take,
    output logic              tx_line,
    output logic              tx_end
);

    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   len;
    logic               last;
    frame_t             nxt;

    assign last    = busy && (cnt == len - CNT_W'(1));
    assign take    = tick && tx_enable && hold_full && (!busy || last);
    assign nxt     = build_frame(hold_data, fmt, aux_bit);
    assign tx_line = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            shreg  <= '1;
            cnt    <= '0;
            len    <= '0;
            tx_end <= 1'b1;
        end else if (tick) begin
            if (take) begin
                shreg  <= nxt.bits;
                len    <= nxt.len;
                cnt    <= '0;
                busy   <= 1'b1;
                tx_end <= 1'b0;
            end else if (last) begin
                busy   <= 1'b0;
                shreg  <= '1;
                tx_end <= 1'b1;
            end else if (busy) begin
                shreg  <= {1'b1, shreg[FRAME_W-1:1]};
                cnt    <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              tx_enable,
    input  logic [1:0]        fmt,
    input  logic              aux_bit,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              tx_end
);

    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    sertx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_enable  (tx_enable),
        .take       (take),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .hold_empty (hold_empty)
    );

    sertx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_enable  (tx_enable),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .fmt        (fmt_e'(fmt)),
        .aux_bit    (aux_bit),
        .take       (take),
        .tx_line    (tx_line),
        .tx_end     (tx_end)
    );

endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic tick,
    input logic tx_enable,
    input logic tx_line,
    input logic hold_empty,
    input logic tx_end
);

    // R4
    line_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx_line));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> tx_line);

    // R2
    write_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && wr_en) |=> !hold_empty);

    // R2
    no_spurious_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && !wr_en) |=> hold_empty);

    // R3
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && tx_end) |=> tx_end);

    // R8
    end_fall_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_end) |-> $past(tick));

    // R8
    end_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_end) |-> ($past(tick) && $past(tx_line)));

endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .tick       (tick),
    .tx_enable  (tx_enable),
    .tx_line    (tx_line),
    .hold_empty (hold_empty),
    .tx_end     (tx_end)
);

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;

    localparam int TICK_GAP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic       aux_bit = 1'b0;
    logic       tx_line;
    logic       hold_empty;
    logic       tx_end;

    int errors = 0;
    int checks = 0;
    int phase = 0;
    bit done = 0;

    // frame decoder state
    logic [10:0] exp_q[$];
    bit          rx_busy = 0;
    int          rx_cnt = 0;
    int          rx_len = 0;
    logic [10:0] rx_vec;
    logic [10:0] rx_exp;
    logic [1:0]  rx_fmt;
    int          idle_run = 0;
    int          frames_got = 0;
    int          batch_frames = 0;
    bit          gapless = 0;

    always #4 clk = ~clk;

    sertx_dbuf u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tick       (tick),
        .tx_enable  (tx_enable),
        .fmt        (fmt),
        .aux_bit    (aux_bit),
        .tx_line    (tx_line),
        .hold_empty (hold_empty),
        .tx_end     (tx_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // packed entry: {aux, fmt[1:0], data[7:0]}
    function automatic void exp_frame(input logic [10:0] e, output logic [10:0] v, output int n);
        logic [7:0] d;
        d = e[7:0];
        v = {2'b11, d, 1'b0};
        case (e[9:8])
            2'd0: n = 10;
            2'd1: n = 11;
            2'd2: begin v[9] = (^d) ^ e[10]; n = 11; end
            default: begin v[9] = e[10]; n = 11; end
        endcase
    endfunction

    // Tick generation and line sampling, away from the active edge.
    always @(negedge clk) begin
        if (tick && !rst) begin
            if (!rx_busy) begin
                if (tx_line == 1'b0) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected frame", 1, 0);
                    end else begin
                        logic [10:0] e;
                        e = exp_q.pop_front();
                        exp_frame(e, rx_exp, rx_len);
                        rx_fmt = e[9:8];
                        rx_busy = 1;
                        rx_cnt = 1;
                        rx_vec = '1;
                        rx_vec[0] = 1'b0;
                        chk(tx_end == 1'b0, "R8 tx_end low at start", int'(tx_end), 0);
                        if (gapless && batch_frames > 0)
                            chk(idle_run == 0, "R9 gap between frames", idle_run, 0);
                        batch_frames++;
                    end
                end else begin
                    if (idle_run == 0 && frames_got > 0)
                        chk(tx_end == 1'b1, "R8 tx_end high after stop", int'(tx_end), 1);
                    idle_run++;
                end
            end else begin
                rx_vec[rx_cnt] = tx_line;
                rx_cnt++;
                if (rx_cnt == rx_len) begin
                    logic [10:0] mask;
                    mask = 11'((1 << rx_len) - 1);
                    // R4 ordering plus per-format layout
                    case (rx_fmt)
                        2'd0, 2'd1: chk(((rx_vec ^ rx_exp) & mask) == 0, "R5 frame bits", int'(rx_vec & mask), int'(rx_exp & mask));
                        2'd2:       chk(((rx_vec ^ rx_exp) & mask) == 0, "R6 frame bits", int'(rx_vec & mask), int'(rx_exp & mask));
                        default:    chk(((rx_vec ^ rx_exp) & mask) == 0, "R7 frame bits", int'(rx_vec & mask), int'(rx_exp & mask));
                    endcase
                    rx_busy = 0;
                    idle_run = 0;
                    frames_got++;
                end
            end
        end
        if (rst) begin
            tick = 1'b0;
            phase = 0;
        end else begin
            phase = (phase + 1) % TICK_GAP;
            tick = (phase == 0);
        end
    end

    task automatic send(input logic [7:0] d);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!hold_empty && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        wr_en = 1'b1;
        wr_data = d;
        exp_q.push_back({aux_bit, fmt, d});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet;
        int guard;
        quiet = 0;
        guard = 0;
        while (quiet < 3 * TICK_GAP && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (hold_empty && tx_end && !rx_busy) quiet++;
            else quiet = 0;
        end
    endtask

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        chk(tx_end == 1'b1, "R1 tx_end", int'(tx_end), 1);

        // R3: write while disabled is kept, nothing sent
        send(8'h3C);
        chk(hold_empty == 1'b0, "R2 hold_empty after write", int'(hold_empty), 0);
        repeat (10 * TICK_GAP) @(negedge clk);
        chk(tx_end == 1'b1 && tx_line == 1'b1 && frames_got == 0, "R3 idle while disabled", frames_got, 0);
        // R2: write while full is dropped (no queue entry)
        wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        wr_en = 1'b0;
        tx_enable = 1'b1;
        wait_idle();
        chk(frames_got == 1, "R3 word sent after enable", frames_got, 1);
        chk(exp_q.size() == 0, "R2 dropped write", exp_q.size(), 0);

        // Format sweeps with gapless bursts
        gapless = 1;
        for (int f = 0; f < 4; f++) begin
            for (int b = 0; b < 2; b++) begin
                int cnt;
                fmt = 2'(f);
                aux_bit = 1'(b);
                batch_frames = 0;
                base = frames_got;
                cnt = (f >= 2) ? 256 : 48;
                for (int i = 0; i < cnt; i++) begin
                    if (f >= 2) send(8'(i));
                    else send(8'((i * 53 + 7) % 256));
                end
                wait_idle();
                chk(frames_got - base == cnt, "R9 burst frame count", frames_got - base, cnt);
            end
        end
        gapless = 0;

        // R8: flags differ while one frame is on the line
        fmt = 2'b00;
        aux_bit = 1'b0;
        send(8'hA5);
        while (tx_end) @(negedge clk);
        @(negedge clk);
        chk(hold_empty == 1'b1 && tx_end == 1'b0, "R8 empty while sending", int'(hold_empty), 1);
        send(8'h5A);
        @(negedge clk);
        @(negedge clk);
        chk(hold_empty == 1'b0 && tx_end == 1'b0, "R8 full while sending", int'(hold_empty), 0);
        wait_idle();

        // R10: disable mid-frame
        base = frames_got;
        fmt = 2'b11;
        aux_bit = 1'b1;
        send(8'hC3);
        while (tx_end) @(negedge clk);
        send(8'h18);
        repeat (3 * TICK_GAP) @(negedge clk);
        tx_enable = 1'b0;
        repeat (30 * TICK_GAP) @(negedge clk);
        chk(frames_got - base == 1, "R10 current frame finished", frames_got - base, 1);
        chk(hold_empty == 1'b0, "R10 waiting word kept", int'(hold_empty), 0);
        chk(tx_end == 1'b1 && tx_line == 1'b1, "R10 idle after finish", int'(tx_line), 1);
        tx_enable = 1'b1;
        wait_idle();
        chk(frames_got - base == 2, "R10 waiting word sent", frames_got - base, 2);
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule